// File: doc/BRIEF.md
# Burst Transfer Master

This block is the control side of one bus master on a pipelined shared bus. It issues four-beat incrementing bursts. A one-cycle start command arms a burst. The block then raises its bus request. Once the arbiter has handed it the bus, it emits NONSEQ, then a run of SEQ beats, and returns to IDLE after the last beat so that the bus can be rearbitrated. Addresses, data, beat counting and arbitration all live outside the block. The last-beat flag arrives from the address generator.

Every cycle the block watches the slave's ready and two-bit response.

- A wait state holds a BUSY or SEQ transfer in place.
- A NONSEQ that meets a wait state is withdrawn and issued again once ready returns.
- A two-cycle RETRY makes the master drop to IDLE and then reissue NONSEQ.
- An ERROR cancels the burst.
- A SPLIT parks the master at IDLE, raises a split flag and re-arms the burst for when the bus comes back.

Where the protocol allows either BUSY or SEQ, a static preference pin makes the choice. This keeps the sequence deterministic.

All pins are plain level controls. The block has no streaming interface, so no valid/ready back-pressure applies at its edge.

Top module: `burst_xfer_master`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, trans_o is IDLE (00) and req_o, burst_o and split_o are low.
- R2: Once req_o is high, it stays high in the next cycle whenever grant_i is low.
- R3: When owner_i is high and the current cycle is not a completed transfer (ready_i high with response OKAY, 00), req_o is high in the next cycle.
- R4: trans_o becomes NONSEQ (10) only if, in the cycle before, owner_i and ready_i were high and either the response was OKAY while trans_o was IDLE, or the response was RETRY (10).
- R5: After an owned NONSEQ that completes with ready high and OKAY, the next transfer is BUSY (01) or SEQ (11), and burst_o is 1 (four-beat incrementing; 0 means single/none).
- R6: After an owned SEQ that completes with OKAY, the next transfer is IDLE if last_beat_i was high, and BUSY or SEQ otherwise.
- R7: After an owned BUSY that completes with ready high and OKAY, the next transfer is SEQ.
- R8: While owning the bus, a RETRY response with ready low leads to IDLE, and a RETRY response with ready high leads to NONSEQ.
- R9: While owning the bus, an ERROR response (01) on either cycle leads to IDLE, and the cancelled burst is not reissued without a new start_i.
- R10: While owning the bus, a SPLIT response (11) with ready low leads to IDLE and raises split_o. split_o stays high until the burst is reissued as NONSEQ, which happens once the bus is owned again with ready high and OKAY.
- R11: Wherever BUSY and SEQ are both allowed, busy_pref_i high selects BUSY and busy_pref_i low selects SEQ.
- R12: An owned wait state (ready low, OKAY) holds a BUSY or SEQ transfer unchanged. A NONSEQ that meets a wait state becomes IDLE and is reissued when ready returns.
- R13: start_i high makes req_o high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle command that arms a burst |
| busy_pref_i | input | 1 | Picks BUSY (1) or SEQ (0) where both are legal |
| grant_i | input | 1 | Arbiter grant for this master |
| owner_i | input | 1 | This master currently owns the bus |
| ready_i | input | 1 | Slave ready for the current transfer |
| resp_i | input | 2 | Slave response: 00 OKAY, 01 ERROR, 10 RETRY, 11 SPLIT |
| last_beat_i | input | 1 | Current SEQ is the final beat of the burst |
| req_o | output | 1 | Bus request |
| trans_o | output | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| burst_o | output | 1 | Burst type: 1 four-beat incrementing, 0 single |
| split_o | output | 1 | Burst was split and is waiting to be reissued |

## Verification
The bench targets four cases where the master goes wrong.

- BUSY with the BUSY preference set. A master that obeys the preference blindly here would emit BUSY forever and livelock the bus.
- The last beat. A design that misses it keeps driving SEQ and never hands the bus back for rearbitration.
- The two RETRY cycles against the two ERROR cycles. A design that mixes them up either cancels a transfer it must repeat, or restarts a burst the slave rejected.
- A stall on NONSEQ and the return of ownership after a SPLIT. Getting these wrong shows up as a NONSEQ that persists without ready, or as a parked burst that is never reissued and a split flag that never clears.

// File: rtl/bxm_pkg.sv
package bxm_pkg;
  localparam int TRANS_W = 2;
  localparam int RESP_W  = 2;

  typedef enum logic [TRANS_W-1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } xfer_e;

  typedef enum logic [RESP_W-1:0] {
    RS_OKAY  = 2'b00,
    RS_ERR   = 2'b01,
    RS_RETRY = 2'b10,
    RS_SPLIT = 2'b11
  } resp_e;

  // Response events, all already qualified by bus ownership.
  typedef struct packed {
    logic own;    // master owns the bus this cycle
    logic done;   // transfer completes: ready high, OKAY
    logic stall;  // wait state: ready low, OKAY
    logic err;    // ERROR, either cycle
    logic rty1;   // RETRY first cycle (ready low)
    logic rty2;   // RETRY second cycle (ready high)
    logic spl1;   // SPLIT first cycle (ready low)
    logic spl2;   // SPLIT second cycle (ready high)
  } rsp_ev_t;
endpackage

// File: rtl/bxm_resp_decode.sv
module bxm_resp_decode
  import bxm_pkg::*;
(
  input  logic              owner_i,
  input  logic              ready_i,
  input  logic [RESP_W-1:0] resp_i,
  output rsp_ev_t           ev_o
);
  resp_e rsp;
  assign rsp = resp_e'(resp_i);

  always_comb begin
    ev_o.own   = owner_i;
    ev_o.done  = owner_i &  ready_i & (rsp == RS_OKAY);
    ev_o.stall = owner_i & ~ready_i & (rsp == RS_OKAY);
    ev_o.err   = owner_i & (rsp == RS_ERR);
    ev_o.rty1  = owner_i & ~ready_i & (rsp == RS_RETRY);
    ev_o.rty2  = owner_i &  ready_i & (rsp == RS_RETRY);
    ev_o.spl1  = owner_i & ~ready_i & (rsp == RS_SPLIT);
    ev_o.spl2  = owner_i &  ready_i & (rsp == RS_SPLIT);
  end
endmodule

// File: rtl/bxm_req_keeper.sv
module bxm_req_keeper (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic grant_i,
  input  logic own_i,
  input  logic done_i,
  output logic req_o
);
  logic req_q;
  logic req_n;

  // Raise on a start, keep until granted, keep while an owned transfer is unfinished.
  assign req_n = start_i | (req_q & ~grant_i) | (own_i & ~done_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_n;
  end

  assign req_o = req_q;
endmodule

// File: rtl/bxm_xfer_seq.sv
module bxm_xfer_seq
  import bxm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_i,
  input  logic    busy_pref_i,
  input  logic    last_beat_i,
  input  rsp_ev_t ev_i,
  output xfer_e   trans_o,
  output logic    burst_o,
  output logic    split_o
);
  xfer_e trans_q, trans_n, mid_beat;
  logic  armed_q, armed_n;
  logic  split_q, split_n;
  logic  burst_q;

  assign mid_beat = busy_pref_i ? TR_BUSY : TR_SEQ;

  always_comb begin
    trans_n = trans_q;
    armed_n = armed_q;
    split_n = split_q;
    if (!ev_i.own) begin
      trans_n = TR_IDLE;
    end else if (ev_i.err) begin
      trans_n = TR_IDLE;
      armed_n = 1'b0;
    end else if (ev_i.rty1) begin
      trans_n = TR_IDLE;
    end else if (ev_i.rty2) begin
      trans_n = TR_NSEQ;
    end else if (ev_i.spl1) begin
      trans_n = TR_IDLE;
      armed_n = 1'b1;
      split_n = 1'b1;
    end else if (ev_i.spl2) begin
      trans_n = TR_IDLE;
    end else if (ev_i.stall) begin
      if (trans_q == TR_NSEQ) begin
        trans_n = TR_IDLE;
        armed_n = 1'b1;
      end
    end else if (ev_i.done) begin
      unique case (trans_q)
        TR_IDLE: if (armed_q) begin
          trans_n = TR_NSEQ;
          armed_n = 1'b0;
          split_n = 1'b0;
        end
        TR_NSEQ: trans_n = mid_beat;
        TR_SEQ:  trans_n = last_beat_i ? TR_IDLE : mid_beat;
        TR_BUSY: trans_n = TR_SEQ;
      endcase
    end
    if (start_i) armed_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trans_q <= TR_IDLE;
      armed_q <= 1'b0;
      split_q <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      trans_q <= trans_n;
      armed_q <= armed_n;
      split_q <= split_n;
      burst_q <= (trans_n != TR_IDLE);
    end
  end

  assign trans_o = trans_q;
  assign burst_o = burst_q;
  assign split_o = split_q;
endmodule

// File: rtl/burst_xfer_master.sv
module burst_xfer_master
  import bxm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              busy_pref_i,
  input  logic              grant_i,
  input  logic              owner_i,
  input  logic              ready_i,
  input  logic [RESP_W-1:0] resp_i,
  input  logic              last_beat_i,
  output logic              req_o,
  output logic [TRANS_W-1:0] trans_o,
  output logic              burst_o,
  output logic              split_o
);
  rsp_ev_t ev;
  xfer_e   trans_w;

  bxm_resp_decode u_dec (
    .owner_i (owner_i),
    .ready_i (ready_i),
    .resp_i  (resp_i),
    .ev_o    (ev)
  );

  bxm_req_keeper u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .grant_i (grant_i),
    .own_i   (ev.own),
    .done_i  (ev.done),
    .req_o   (req_o)
  );

  bxm_xfer_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_pref_i (busy_pref_i),
    .last_beat_i (last_beat_i),
    .ev_i        (ev),
    .trans_o     (trans_w),
    .burst_o     (burst_o),
    .split_o     (split_o)
  );

  assign trans_o = trans_w;
endmodule

// File: rtl/burst_xfer_master_chk.sv
module burst_xfer_master_chk
  import bxm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_pref_i,
  input logic              grant_i,
  input logic              owner_i,
  input logic              ready_i,
  input logic [RESP_W-1:0] resp_i,
  input logic              last_beat_i,
  input logic              req_o,
  input logic [TRANS_W-1:0] trans_o,
  input logic              burst_o,
  input logic              split_o
);
  logic ok_rdy;
  assign ok_rdy = owner_i && ready_i && (resp_i == RS_OKAY);

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (trans_o == TR_IDLE && !req_o && !burst_o && !split_o));

  p_req_until_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !grant_i) |=> req_o);

  p_req_while_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_i && !(ready_i && resp_i == RS_OKAY)) |=> req_o);

  p_nseq_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(owner_i && ready_i && ((resp_i == RS_OKAY && trans_o == TR_IDLE) || resp_i == RS_RETRY))
    |=> trans_o != TR_NSEQ);

  p_after_nseq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_rdy && trans_o == TR_NSEQ) |=> ((trans_o == TR_BUSY || trans_o == TR_SEQ) && burst_o));

  p_last_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_rdy && trans_o == TR_SEQ && last_beat_i) |=> trans_o == TR_IDLE);

  p_mid_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_rdy && trans_o == TR_SEQ && !last_beat_i) |=> (trans_o == TR_BUSY || trans_o == TR_SEQ));

  p_busy_then_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_rdy && trans_o == TR_BUSY) |=> trans_o == TR_SEQ);

  p_retry_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_i && !ready_i && resp_i == RS_RETRY) |=> trans_o == TR_IDLE);

  p_retry_second_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_i && ready_i && resp_i == RS_RETRY) |=> trans_o == TR_NSEQ);

  p_error_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_i && resp_i == RS_ERR) |=> trans_o == TR_IDLE);

  p_split_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_i && !ready_i && resp_i == RS_SPLIT) |=> (trans_o == TR_IDLE && split_o));

  p_pref_pick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_rdy && (trans_o == TR_NSEQ || (trans_o == TR_SEQ && !last_beat_i)))
    |=> trans_o == (busy_pref_i ? TR_BUSY : TR_SEQ));

  p_wait_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_i && !ready_i && resp_i == RS_OKAY && (trans_o == TR_BUSY || trans_o == TR_SEQ))
    |=> $stable(trans_o));

  p_wait_nseq_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_i && !ready_i && resp_i == RS_OKAY && trans_o == TR_NSEQ) |=> trans_o == TR_IDLE);

  p_start_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> req_o);
endmodule

bind burst_xfer_master burst_xfer_master_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_pref_i (busy_pref_i),
  .grant_i     (grant_i),
  .owner_i     (owner_i),
  .ready_i     (ready_i),
  .resp_i      (resp_i),
  .last_beat_i (last_beat_i),
  .req_o       (req_o),
  .trans_o     (trans_o),
  .burst_o     (burst_o),
  .split_o     (split_o)
);

// File: tb/burst_xfer_master_test.sv
`timescale 1ns/1ps
module burst_xfer_master_test;
  localparam int T_IDLE = 0, T_BUSY = 1, T_NSEQ = 2, T_SEQ = 3;
  localparam logic [1:0] OK = 2'b00, ERR = 2'b01, RTY = 2'b10, SPL = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, busy_pref_i = 1'b0, grant_i = 1'b0, owner_i = 1'b0;
  logic ready_i = 1'b0, last_beat_i = 1'b0;
  logic [1:0] resp_i = 2'b00;
  logic req_o, burst_o, split_o;
  logic [1:0] trans_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  typedef struct {
    string tag;
    int et, er, es, eb;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  burst_xfer_master uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_pref_i(busy_pref_i),
    .grant_i(grant_i), .owner_i(owner_i), .ready_i(ready_i), .resp_i(resp_i),
    .last_beat_i(last_beat_i), .req_o(req_o), .trans_o(trans_o),
    .burst_o(burst_o), .split_o(split_o)
  );

  task automatic cmp(input string what, input string tag, input int act, input int exp);
    if (exp < 0) return;
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: apply one cycle of inputs and queue what must appear after the next edge.
  task automatic step(input logic g, input logic o, input logic rdy, input logic [1:0] rs,
                      input logic lb, input logic st, input string tag,
                      input int et, input int er = -1, input int es = -1, input int eb = -1);
    exp_t it;
    @(negedge clk);
    grant_i = g; owner_i = o; ready_i = rdy; resp_i = rs;
    last_beat_i = lb; start_i = st;
    it.tag = tag; it.et = et; it.er = er; it.es = es; it.eb = eb;
    sb.push_back(it);
  endtask

  // Monitor: after each edge, pop the expected item and compare.
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      cmp("trans", it.tag, int'(trans_o), it.et);
      cmp("req",   it.tag, int'(req_o),   it.er);
      cmp("split", it.tag, int'(split_o), it.es);
      cmp("burst", it.tag, int'(burst_o), it.eb);
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    step(0,0,1,OK,0,0,"R1", T_IDLE, 0, 0, 0);
    // SEQ preference, request handshake
    step(0,0,1,OK,0,1,"R13", T_IDLE, 1);
    step(0,0,1,OK,0,0,"R2", T_IDLE, 1);
    step(1,0,1,OK,0,0,"R4 not owner", T_IDLE, 0);
    step(1,1,1,OK,0,0,"R4", T_NSEQ, 0, -1, 1);
    step(1,1,1,OK,0,0,"R5/R11", T_SEQ, -1, -1, 1);
    step(1,1,0,OK,0,0,"R12/R3", T_SEQ, 1);
    step(1,1,1,OK,0,0,"R6", T_SEQ, 0);
    step(1,1,1,OK,0,0,"R6", T_SEQ);
    step(1,1,1,OK,1,0,"R6 last", T_IDLE, -1, -1, 0);
    step(1,1,1,OK,0,0,"R4 no start", T_IDLE);
    // BUSY preference
    busy_pref_i = 1'b1;
    step(1,1,1,OK,0,1,"R13", T_IDLE, 1);
    step(1,1,1,OK,0,0,"R4", T_NSEQ);
    step(1,1,1,OK,0,0,"R11 busy", T_BUSY, -1, -1, 1);
    step(1,1,1,OK,0,0,"R7", T_SEQ);
    step(1,1,1,OK,0,0,"R11 busy", T_BUSY);
    step(1,1,1,OK,0,0,"R7", T_SEQ);
    step(1,1,1,OK,1,0,"R6 last", T_IDLE);
    busy_pref_i = 1'b0;
    // RETRY
    step(1,1,1,OK,0,1,"R13", T_IDLE, 1);
    step(1,1,1,OK,0,0,"R4", T_NSEQ);
    step(1,1,0,RTY,0,0,"R8 first", T_IDLE, 1);
    step(1,1,1,RTY,0,0,"R8 second", T_NSEQ, 1);
    step(1,1,1,OK,0,0,"R5", T_SEQ);
    // ERROR on both cycles
    step(1,1,0,ERR,0,0,"R9 first", T_IDLE);
    step(1,1,1,ERR,0,0,"R9 second", T_IDLE);
    step(1,1,1,OK,0,0,"R9 no reissue", T_IDLE);
    // ERROR seen only on the ready-high cycle
    step(1,1,1,OK,0,1,"R13", T_IDLE, 1);
    step(1,1,1,OK,0,0,"R4", T_NSEQ);
    step(1,1,1,OK,0,0,"R5", T_SEQ);
    step(1,1,1,ERR,0,0,"R9", T_IDLE);
    step(1,1,1,OK,0,0,"R9 no reissue", T_IDLE);
    // SPLIT
    step(1,1,1,OK,0,1,"R13", T_IDLE, 1);
    step(1,1,1,OK,0,0,"R4", T_NSEQ, -1, 0);
    step(1,1,0,SPL,0,0,"R10 first", T_IDLE, 1, 1);
    step(1,1,1,SPL,0,0,"R10 second", T_IDLE, 1, 1);
    step(0,0,1,OK,0,0,"R10/R2 parked", T_IDLE, 1, 1);
    step(1,1,1,OK,0,0,"R10 reissue", T_NSEQ, -1, 0);
    step(1,1,1,OK,0,0,"R5", T_SEQ);
    step(1,1,1,OK,1,0,"R6 last", T_IDLE);
    // NONSEQ against wait states
    step(1,1,0,OK,0,1,"R13", T_IDLE, 1);
    step(1,1,0,OK,0,0,"R4 ready low", T_IDLE);
    step(1,1,1,OK,0,0,"R4", T_NSEQ);
    step(1,1,0,OK,0,0,"R12 withdraw", T_IDLE, 1);
    step(1,1,1,OK,0,0,"R12 reissue", T_NSEQ);
    step(1,1,1,OK,0,0,"R5", T_SEQ);
    step(1,1,1,OK,1,0,"R6 last", T_IDLE);
    step(1,1,1,OK,0,0,"R6 settled", T_IDLE);
    repeat (4) @(posedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule